// File: doc/BRIEF.md
# External Bus Chip-Select Controller

This block carries single read and write requests from an internal request port out to slow asynchronous memories and I/O devices that share one 32-bit data bus. Each request address is compared against six chip-select windows. The matching channel's settings then shape the whole access: the device data width, how many internal clocks make up one external bus tick, how many ticks the address and chip enable lead the strobe and trail it, and whether the byte strobes also mark lanes on reads. A request that no enabled window claims is answered at once with an error and leaves the bus untouched.

A 32-bit request to a narrow device is broken into successive bus cycles, with the lowest byte address first. Every bus cycle holds its read or write strobe until the device acknowledges it on an active-low ready line, sampled only at bus-tick boundaries. Read bytes from the narrow cycles are gathered into one word, and the request completes with a one-cycle done pulse once the last cycle has released its chip enable.

Top module: `xbus_cs_ctrl`

## Requirements
- R1: Channel i claims an address when its enable is set and the address matches its base on every bit of the effective mask. When several channels claim, the lowest index wins. Only the winning chip enable (bus_ce_n[i], active low) is driven, so at most one is ever low.
- R2: The effective mask ignores address bits 19:0, which gives a 1 MB minimum window. It always compares bits 31:30 on 32-bit channels, 31:29 on 16-bit channels and 31:28 on 8-bit channels. Width code 0 means 32 bits, 1 means 16 bits, and 2 or 3 means 8 bits.
- R3: A request accepted with no claiming channel gives resp_done and resp_err together in the cycle after acceptance. No chip enable or strobe is asserted for it.
- R4: A request becomes 1, 2 or 4 bus cycles on 32-, 16- or 8-bit channels. Cycle k drives bus_addr = word address (bits 1:0 cleared) + k×2 on 16-bit channels and + k on 8-bit channels, with cycle 0 first.
- R5: Byte strobe lane n (bus_be_n[n], active low) covers data bits 8n+7:8n and goes low for a set req_be bit. A 32-bit cycle uses all four lanes. A 16-bit cycle k drives req_be[2k+1:2k] on lanes 1:0, and an 8-bit cycle k drives req_be[k] on lane 0. Lanes that are not used stay high.
- R6: When cfg_bwe is 0 for a channel, byte strobes are driven on reads and writes. When it is 1, they are driven on writes only and stay high on reads.
- R7: One bus tick is div+1 internal cycles. The chip enable and address lead the strobe by setup ticks and stay valid for hold ticks after the strobe is released. Each count may be zero.
- R8: The strobe (bus_oe_n for reads, bus_we_n for writes) lasts at least one tick. It ends at the first tick boundary at which bus_ack_n is sampled low.
- R9: Read data is taken from bus_din at the acknowledging tick: all 32 bits on a 32-bit cycle, bits 15:0 into resp_rdata[16k+15:16k] on a 16-bit cycle, and bits 7:0 into resp_rdata[8k+7:8k] on an 8-bit cycle.
- R10: During a write, bus_doe is high and bus_dout carries the whole word on a 32-bit cycle, req_wdata[16k+15:16k] in bits 15:0 on a 16-bit cycle, or req_wdata[8k+7:8k] in bits 7:0 on an 8-bit cycle, with the bits above driven zero.
- R11: All chip enables are high for exactly one cycle after each bus cycle. resp_done pulses for one cycle in that gap after the last bus cycle, with resp_err low.
- R12: While idle (req_ready high), every chip enable and strobe is high. bus_oe_n goes low only for reads and bus_we_n only for writes, and never without a chip enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request byte address |
| req_be | input | 4 | Byte enables of the request word |
| req_wdata | input | 32 | Write data word |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | No channel claimed the address |
| resp_rdata | output | 32 | Assembled read word, valid with resp_done |
| cfg_en | input | NCH | Per-channel enable |
| cfg_base | input | NCH*32 | Per-channel window base |
| cfg_mask | input | NCH*32 | Per-channel compare mask |
| cfg_width | input | NCH*2 | Per-channel width code |
| cfg_div | input | NCH*2 | Per-channel tick length minus one |
| cfg_setup | input | NCH*SETUP_W | Per-channel setup ticks |
| cfg_hold | input | NCH*HOLD_W | Per-channel hold ticks |
| cfg_bwe | input | NCH | Per-channel write-only byte strobe style |
| bus_addr | output | 32 | External address |
| bus_ce_n | output | NCH | Chip enables, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_be_n | output | 4 | Byte strobes, active low |
| bus_dout | output | 32 | Write data to the bus |
| bus_doe | output | 1 | Drive enable for bus_dout |
| bus_din | input | 32 | Read data from the bus |
| bus_ack_n | input | 1 | Acknowledge / ready, active low |

## Verification
The channels are given different widths, tick lengths, setup and hold counts and strobe styles. Random reads and writes with random byte enables and random acknowledge delays therefore show whether each setting is taken from the right channel. Directed addresses target the overlap of two windows, mask bits that must be ignored or forced, a disabled channel, and unclaimed space, which separates priority, effective-mask and miss handling. Acknowledge delays shorter than, equal to and longer than a tick show whether ready is sampled only at tick boundaries. Read data that depends on the address shows whether each narrow cycle's bytes land in the right place in the assembled word.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ADDR = 3'd1,
    S_STRB = 3'd2,
    S_HOLD = 3'd3,
    S_GAP  = 3'd4,
    S_MISS = 3'd5
  } st_e;

  // Compare mask actually used: 1 MB floor, per-width ceiling on window size.
  function automatic logic [ADDR_W-1:0] eff_mask(input logic [ADDR_W-1:0] m,
                                                 input logic [1:0] w);
    logic [ADDR_W-1:0] force_hi;
    case (w)
      2'd0:    force_hi = 32'hC000_0000;
      2'd1:    force_hi = 32'hE000_0000;
      default: force_hi = 32'hF000_0000;
    endcase
    return (m | force_hi) & 32'hFFF0_0000;
  endfunction

  function automatic logic [1:0] last_beat(input logic [1:0] w);
    case (w)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [1:0] w,
                                                  input logic [1:0] k);
    logic [ADDR_W-1:0] word;
    word = {a[ADDR_W-1:2], 2'b00};
    case (w)
      2'd0:    return word;
      2'd1:    return word | {{(ADDR_W-2){1'b0}}, k[0], 1'b0};
      default: return word | {{(ADDR_W-2){1'b0}}, k};
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_strb_n(input logic [LANES-1:0] be,
                                                   input logic [1:0] w,
                                                   input logic [1:0] k);
    case (w)
      2'd0:    return ~be;
      2'd1:    return {2'b11, ~(k[0] ? be[3:2] : be[1:0])};
      default: return {3'b111, ~be[k]};
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_wdata(input logic [DATA_W-1:0] wd,
                                                   input logic [1:0] w,
                                                   input logic [1:0] k);
    case (w)
      2'd0:    return wd;
      2'd1:    return {16'h0000, (k[0] ? wd[31:16] : wd[15:0])};
      default: return {24'h00_0000, wd[k*8 +: 8]};
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] merge_rdata(input logic [DATA_W-1:0] acc,
                                                    input logic [DATA_W-1:0] din,
                                                    input logic [1:0] w,
                                                    input logic [1:0] k);
    logic [DATA_W-1:0] res;
    res = acc;
    case (w)
      2'd0:    res = din;
      2'd1:    res[k[0]*16 +: 16] = din[15:0];
      default: res[k*8 +: 8] = din[7:0];
    endcase
    return res;
  endfunction

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int unsigned NCH   = 6,
  parameter int unsigned IDX_W = 3
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NCH-1:0]        en,
  input  logic [NCH*ADDR_W-1:0] base,
  input  logic [NCH*ADDR_W-1:0] mask,
  input  logic [NCH*2-1:0]      width,
  output logic                  hit,
  output logic [IDX_W-1:0]      sel
);

  logic [NCH-1:0] match;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [ADDR_W-1:0] m_eff;
    assign m_eff    = eff_mask(mask[g*ADDR_W +: ADDR_W], width[g*2 +: 2]);
    assign match[g] = en[g] &&
                      (((addr ^ base[g*ADDR_W +: ADDR_W]) & m_eff) == '0);
  end

  // Scan from the top so the lowest claiming index is the one left standing.
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/xbus_tick.sv
module xbus_tick #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == div) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == div);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_hit,
  input  logic [PH_W-1:0] setup_n,
  input  logic [PH_W-1:0] hold_n,
  input  logic [1:0]      last_bt,
  input  logic            tick,
  input  logic            ack_n,
  output st_e             st,
  output logic [1:0]      beat,
  output logic            cap
);

  logic [PH_W-1:0] ph;

  assign cap = (st == S_STRB) && tick && !ack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= '0;
      beat <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            beat <= '0;
            ph   <= setup_n;
            if (!start_hit)         st <= S_MISS;
            else if (setup_n == '0) st <= S_STRB;
            else                    st <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (tick) begin
            if (ph == PH_W'(1)) st <= S_STRB;
            ph <= ph - 1'b1;
          end
        end
        S_STRB: begin
          if (cap) begin
            ph <= hold_n;
            st <= (hold_n == '0) ? S_GAP : S_HOLD;
          end
        end
        S_HOLD: begin
          if (tick) begin
            if (ph == PH_W'(1)) st <= S_GAP;
            ph <= ph - 1'b1;
          end
        end
        S_GAP: begin
          if (beat == last_bt) begin
            st <= S_IDLE;
          end else begin
            beat <= beat + 1'b1;
            ph   <= setup_n;
            st   <= (setup_n == '0) ? S_STRB : S_ADDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xbus_lanes.sv
module xbus_lanes
  import xbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic [1:0]        w,
  input  logic [1:0]        k,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  output logic [LANES-1:0]  strb_n,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rdata
);

  assign strb_n = lane_strb_n(be, w, k);
  assign dout   = lane_wdata(wdata, w, k);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (clr) begin
      rdata <= '0;
    end else if (cap) begin
      rdata <= merge_rdata(rdata, din, w, k);
    end
  end

endmodule

// File: rtl/xbus_cs_ctrl.sv
module xbus_cs_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned NCH     = 6,
  parameter int unsigned SETUP_W = 4,
  parameter int unsigned HOLD_W  = 4,
  parameter int unsigned DIV_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [31:0]            req_addr,
  input  logic [3:0]             req_be,
  input  logic [31:0]            req_wdata,
  output logic                   resp_done,
  output logic                   resp_err,
  output logic [31:0]            resp_rdata,
  input  logic [NCH-1:0]         cfg_en,
  input  logic [NCH*32-1:0]      cfg_base,
  input  logic [NCH*32-1:0]      cfg_mask,
  input  logic [NCH*2-1:0]       cfg_width,
  input  logic [NCH*DIV_W-1:0]   cfg_div,
  input  logic [NCH*SETUP_W-1:0] cfg_setup,
  input  logic [NCH*HOLD_W-1:0]  cfg_hold,
  input  logic [NCH-1:0]         cfg_bwe,
  output logic [31:0]            bus_addr,
  output logic [NCH-1:0]         bus_ce_n,
  output logic                   bus_oe_n,
  output logic                   bus_we_n,
  output logic [3:0]             bus_be_n,
  output logic [31:0]            bus_dout,
  output logic                   bus_doe,
  input  logic [31:0]            bus_din,
  input  logic                   bus_ack_n
);

  localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned PH_W  = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;

  // Decode of the incoming request
  logic             dec_hit;
  logic [IDX_W-1:0] dec_sel;

  xbus_decode #(.NCH(NCH), .IDX_W(IDX_W)) u_dec (
    .addr  (req_addr),
    .en    (cfg_en),
    .base  (cfg_base),
    .mask  (cfg_mask),
    .width (cfg_width),
    .hit   (dec_hit),
    .sel   (dec_sel)
  );

  // Latched request and channel settings for the access in flight
  logic [IDX_W-1:0]   act_ch;
  logic [31:0]        act_addr;
  logic               act_wr;
  logic [3:0]         act_be;
  logic [31:0]        act_wd;
  logic [1:0]         act_w;
  logic [DIV_W-1:0]   act_div;
  logic [SETUP_W-1:0] act_setup;
  logic [HOLD_W-1:0]  act_hold;
  logic               act_bwe;

  st_e        st;
  logic [1:0] beat;
  logic       cap;
  logic       tick;
  logic       accept;
  logic       bus_active;
  logic       in_strobe;
  logic       last_done;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ch    <= '0;
      act_addr  <= '0;
      act_wr    <= 1'b0;
      act_be    <= '0;
      act_wd    <= '0;
      act_w     <= '0;
      act_div   <= '0;
      act_setup <= '0;
      act_hold  <= '0;
      act_bwe   <= 1'b0;
    end else if (accept && dec_hit) begin
      act_ch    <= dec_sel;
      act_addr  <= req_addr;
      act_wr    <= req_write;
      act_be    <= req_be;
      act_wd    <= req_wdata;
      act_w     <= cfg_width[dec_sel*2 +: 2];
      act_div   <= cfg_div[dec_sel*DIV_W +: DIV_W];
      act_setup <= cfg_setup[dec_sel*SETUP_W +: SETUP_W];
      act_hold  <= cfg_hold[dec_sel*HOLD_W +: HOLD_W];
      act_bwe   <= cfg_bwe[dec_sel];
    end
  end

  // Setup count is taken straight from the decoder at start, later from the latch.
  logic [PH_W-1:0] seq_setup;
  assign seq_setup = (st == S_IDLE) ? PH_W'(cfg_setup[dec_sel*SETUP_W +: SETUP_W])
                                    : PH_W'(act_setup);

  assign bus_active = (st == S_ADDR) || (st == S_STRB) || (st == S_HOLD);
  assign in_strobe  = (st == S_STRB);

  xbus_tick #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (bus_active),
    .div   (act_div),
    .tick  (tick)
  );

  xbus_seq #(.PH_W(PH_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_hit (dec_hit),
    .setup_n   (seq_setup),
    .hold_n    (PH_W'(act_hold)),
    .last_bt   (last_beat(act_w)),
    .tick      (tick),
    .ack_n     (bus_ack_n),
    .st        (st),
    .beat      (beat),
    .cap       (cap)
  );

  logic [3:0]  lane_strb_raw;
  logic [31:0] lane_dout_raw;

  xbus_lanes u_lanes (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .cap    (cap),
    .w      (act_w),
    .k      (beat),
    .be     (act_be),
    .wdata  (act_wd),
    .din    (bus_din),
    .strb_n (lane_strb_raw),
    .dout   (lane_dout_raw),
    .rdata  (resp_rdata)
  );

  // Pin drive
  for (genvar g = 0; g < NCH; g++) begin : g_ce
    assign bus_ce_n[g] = !(bus_active && (act_ch == IDX_W'(g)));
  end

  assign bus_addr  = bus_active ? beat_addr(act_addr, act_w, beat) : '0;
  assign bus_oe_n  = !(in_strobe && !act_wr);
  assign bus_we_n  = !(in_strobe && act_wr);
  assign bus_be_n  = (in_strobe && (act_wr || !act_bwe)) ? lane_strb_raw : 4'hF;
  assign bus_doe   = bus_active && act_wr;
  assign bus_dout  = bus_doe ? lane_dout_raw : '0;

  assign last_done = (st == S_GAP) && (beat == last_beat(act_w));
  assign resp_done = last_done || (st == S_MISS);
  assign resp_err  = (st == S_MISS);

endmodule

// File: rtl/xbus_cs_chk.sv
module xbus_cs_chk #(
  parameter int unsigned NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           resp_done,
  input logic           resp_err,
  input logic [NCH-1:0] bus_ce_n,
  input logic           bus_oe_n,
  input logic           bus_we_n,
  input logic [3:0]     bus_be_n,
  input logic           bus_ack_n,
  input logic           bus_active,
  input logic           act_wr,
  input logic           act_bwe,
  input logic [1:0]     act_w
);

  AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_ce_n)); // R1

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (&bus_ce_n && bus_oe_n && bus_we_n)); // R3

  AST_LANES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && act_w == 2'd1) |-> (&bus_be_n[3:2])); // R5

  AST_LANES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && act_w[1]) |-> (&bus_be_n[3:1])); // R5

  AST_BWE_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && act_bwe && !act_wr) |-> (&bus_be_n)); // R6

  AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n && bus_ack_n) |=> !bus_oe_n); // R8

  AST_WE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n && bus_ack_n) |=> !bus_we_n); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done); // R11

  AST_DONE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |-> (&bus_ce_n)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&bus_ce_n && bus_oe_n && bus_we_n && (&bus_be_n))); // R12

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> (!act_wr && !(&bus_ce_n))); // R12

  AST_WE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> (act_wr && !(&bus_ce_n))); // R12

endmodule

bind xbus_cs_ctrl xbus_cs_chk #(.NCH(NCH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .resp_done  (resp_done),
  .resp_err   (resp_err),
  .bus_ce_n   (bus_ce_n),
  .bus_oe_n   (bus_oe_n),
  .bus_we_n   (bus_we_n),
  .bus_be_n   (bus_be_n),
  .bus_ack_n  (bus_ack_n),
  .bus_active (bus_active),
  .act_wr     (act_wr),
  .act_bwe    (act_bwe),
  .act_w      (act_w)
);

// File: tb/xbus_cs_ctrl_tb_top.sv
module xbus_cs_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, resp_done, resp_err;
  logic [31:0] resp_rdata;
  logic [31:0] bus_addr, bus_dout, bus_din;
  logic [NCH-1:0] bus_ce_n;
  logic        bus_oe_n, bus_we_n, bus_doe;
  logic [3:0]  bus_be_n;
  logic        bus_ack_n = 1'b1;

  logic [31:0] c_base [NCH];
  logic [31:0] c_mask [NCH];
  logic [1:0]  c_w    [NCH];
  logic [1:0]  c_div  [NCH];
  logic [3:0]  c_set  [NCH];
  logic [3:0]  c_hold [NCH];
  logic        c_bwe  [NCH];
  logic        c_en   [NCH];

  logic [NCH-1:0]    cfg_en, cfg_bwe;
  logic [NCH*32-1:0] cfg_base, cfg_mask;
  logic [NCH*2-1:0]  cfg_width, cfg_div;
  logic [NCH*4-1:0]  cfg_setup, cfg_hold;

  for (genvar g = 0; g < NCH; g++) begin : g_cfg
    assign cfg_en[g]           = c_en[g];
    assign cfg_bwe[g]          = c_bwe[g];
    assign cfg_base[g*32 +: 32] = c_base[g];
    assign cfg_mask[g*32 +: 32] = c_mask[g];
    assign cfg_width[g*2 +: 2] = c_w[g];
    assign cfg_div[g*2 +: 2]   = c_div[g];
    assign cfg_setup[g*4 +: 4] = c_set[g];
    assign cfg_hold[g*4 +: 4]  = c_hold[g];
  end

  function automatic logic [31:0] tb_hash(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1357_9BDF;
  endfunction

  assign bus_din = tb_hash(bus_addr);

  xbus_cs_ctrl #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .resp_done(resp_done), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .cfg_width(cfg_width), .cfg_div(cfg_div), .cfg_setup(cfg_setup),
    .cfg_hold(cfg_hold), .cfg_bwe(cfg_bwe),
    .bus_addr(bus_addr), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_be_n(bus_be_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_ack_n(bus_ack_n)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Bench view of the window decode (R1, R2)
  function automatic int tb_chan(input logic [31:0] a);
    for (int i = 0; i < NCH; i++) begin
      logic [31:0] m;
      m = c_mask[i] & 32'hFFF0_0000;
      if (c_w[i] == 2'd0)      m = m | 32'hC000_0000;
      else if (c_w[i] == 2'd1) m = m | 32'hE000_0000;
      else                     m = m | 32'hF000_0000;
      if (c_en[i] && (((a ^ c_base[i]) & m) == 32'h0)) return i;
    end
    return -1;
  endfunction

  function automatic int tb_beats(input logic [1:0] w);
    return (w == 2'd0) ? 1 : ((w == 2'd1) ? 2 : 4);
  endfunction

  function automatic logic [3:0] tb_strb(input logic [3:0] be, input int nb,
                                         input int k, input bit wr, input bit bwe);
    if (bwe && !wr) return 4'hF;
    if (nb == 1) return ~be;
    if (nb == 2) return {2'b11, ~be[2*k +: 2]};
    return {3'b111, ~be[k]};
  endfunction

  task automatic access(input logic [31:0] a, input bit wr, input logic [3:0] be,
                        input logic [31:0] wd, input int w_ack);
    int ch, nb, d, k, setc, strc, holdc, cyc;
    bit done, expect_ce, first;
    logic [31:0] exp_rd, ba, h;
    ch = tb_chan(a);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (ch < 0) begin
      chk(resp_done && resp_err && (&bus_ce_n) && bus_oe_n && bus_we_n, "R3 miss",
          {resp_done, resp_err, 24'h0, bus_ce_n}, {2'b11, 24'h0, 6'h3F});
      return;
    end
    nb = tb_beats(c_w[ch]);
    d = int'(c_div[ch]) + 1;
    exp_rd = 32'h0;
    for (int i = 0; i < nb; i++) begin
      ba = (a & 32'hFFFF_FFFC) + 32'(i * (4 / nb));
      h = tb_hash(ba);
      if (nb == 1) exp_rd = h;
      else if (nb == 2) exp_rd[16*i +: 16] = h[15:0];
      else exp_rd[8*i +: 8] = h[7:0];
    end
    k = 0; setc = 0; strc = 0; holdc = 0; cyc = 0;
    done = 1'b0; expect_ce = 1'b0; first = 1'b1;
    while (!done && cyc < 3000) begin
      if (&bus_ce_n) begin
        chk(!expect_ce, "R11 gap length", {26'h0, bus_ce_n}, 32'h0);
        chk(setc == int'(c_set[ch]) * d, "R7 setup", setc, int'(c_set[ch]) * d);
        chk(strc == d * (w_ack / d + 1), "R8 strobe", strc, d * (w_ack / d + 1));
        chk(holdc == int'(c_hold[ch]) * d, "R7 hold", holdc, int'(c_hold[ch]) * d);
        k++;
        if (resp_done) begin
          chk(k == nb && !resp_err, "R4 R11 beats", k, nb);
          if (!wr) chk(resp_rdata == exp_rd, "R9 read data", resp_rdata, exp_rd);
          done = 1'b1;
        end else begin
          expect_ce = 1'b1;
        end
        setc = 0; strc = 0; holdc = 0; first = 1'b1;
        bus_ack_n = 1'b1;
      end else begin
        expect_ce = 1'b0;
        if (first) begin
          first = 1'b0;
          ba = (a & 32'hFFFF_FFFC) + 32'(k * (4 / nb));
          chk(bus_ce_n == ~(6'(1) << ch), "R1 chip enable", {26'h0, bus_ce_n},
              {26'h0, ~(6'(1) << ch)});
          chk(bus_addr == ba, "R4 beat address", bus_addr, ba);
          chk(bus_doe == wr, "R10 drive enable", bus_doe, wr);
        end
        if (!bus_oe_n || !bus_we_n) begin
          strc++;
          if (strc == 1) begin
            chk(bus_we_n == !wr && bus_oe_n == wr, "R12 strobe kind",
                {bus_oe_n, bus_we_n}, {wr, !wr});
            chk(bus_be_n == tb_strb(be, nb, k, wr, c_bwe[ch]), "R5 R6 byte strobes",
                bus_be_n, tb_strb(be, nb, k, wr, c_bwe[ch]));
            if (wr) begin
              if (nb == 1) h = wd;
              else if (nb == 2) h = {16'h0, wd[16*k +: 16]};
              else h = {24'h0, wd[8*k +: 8]};
              chk(bus_dout == h, "R10 write lanes", bus_dout, h);
            end
          end
          bus_ack_n = !(strc > w_ack);
        end else begin
          bus_ack_n = 1'b1;
          if (strc == 0) setc++;
          else holdc++;
        end
      end
      cyc++;
      if (!done) @(negedge clk);
    end
    chk(done, "R11 completion", done, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    c_en[0]=1; c_base[0]=32'h0000_0000; c_mask[0]=32'hFFF0_0000; c_w[0]=0; c_div[0]=0; c_set[0]=1; c_hold[0]=1; c_bwe[0]=0;
    c_en[1]=1; c_base[1]=32'h1000_0000; c_mask[1]=32'hFFFF_FFFF; c_w[1]=1; c_div[1]=1; c_set[1]=2; c_hold[1]=0; c_bwe[1]=1;
    c_en[2]=1; c_base[2]=32'h2000_0000; c_mask[2]=32'h0000_0000; c_w[2]=2; c_div[2]=2; c_set[2]=0; c_hold[2]=2; c_bwe[2]=0;
    c_en[3]=1; c_base[3]=32'hC000_0000; c_mask[3]=32'h0000_0000; c_w[3]=0; c_div[3]=3; c_set[3]=0; c_hold[3]=0; c_bwe[3]=1;
    c_en[4]=0; c_base[4]=32'h4000_0000; c_mask[4]=32'hFFF0_0000; c_w[4]=0; c_div[4]=0; c_set[4]=1; c_hold[4]=1; c_bwe[4]=0;
    c_en[5]=1; c_base[5]=32'h0000_0000; c_mask[5]=32'hF000_0000; c_w[5]=3; c_div[5]=1; c_set[5]=3; c_hold[5]=1; c_bwe[5]=0;
    repeat (3) @(negedge clk);
    chk(req_ready && (&bus_ce_n) && bus_oe_n && bus_we_n && bus_be_n == 4'hF && !resp_done,
        "R12 reset state", {req_ready, bus_oe_n, bus_we_n, bus_be_n, bus_ce_n}, 32'h1FFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && (&bus_ce_n), "R12 idle after reset", {31'h0, req_ready}, 32'h1);

    // Directed corners
    access(32'h0000_1000, 1'b0, 4'hF, 32'h0, 0);          // R1 overlap, ch0 wins
    access(32'h0010_0004, 1'b1, 4'hA, 32'hCAFE_F00D, 2);  // R1 ch5, 8-bit R5
    access(32'h1000_1234, 1'b0, 4'hF, 32'h0, 3);          // R2 low mask bits ignored, R6 read
    access(32'h1000_1234, 1'b1, 4'h6, 32'h1122_3344, 1);  // R6 write, R10
    access(32'h1010_0000, 1'b0, 4'hF, 32'h0, 0);          // R2 outside 1 MB -> miss R3
    access(32'h2ABC_DE01, 1'b0, 4'hF, 32'h0, 5);          // R2 forced 31:28, R9
    access(32'hF000_0000, 1'b1, 4'h9, 32'hA5A5_5A5A, 0);  // R2 1 GB window, R8 fast ack
    access(32'h4000_0010, 1'b0, 4'hF, 32'h0, 0);          // R1 disabled -> R3
    access(32'h3000_0000, 1'b1, 4'hF, 32'h0, 0);          // R3 unclaimed write

    for (int n = 0; n < 220; n++) begin
      logic [31:0] a, r;
      int sel;
      r = $urandom;
      sel = int'($urandom % 6);
      case (sel)
        0: a = r & 32'h000F_FFFF;
        1: a = 32'h1000_0000 | (r & 32'h000F_FFFF);
        2: a = 32'h2000_0000 | (r & 32'h0FFF_FFFF);
        3: a = 32'hC000_0000 | (r & 32'h3FFF_FFFF);
        4: a = 32'h0010_0000 + (r % 32'h0FF0_0000);
        default: a = 32'h3000_0000 + (r % 32'h9000_0000);
      endcase
      access(a, 1'($urandom), 4'($urandom), $urandom, int'($urandom % 7));
    end

    repeat (2) @(negedge clk);
    chk(req_ready && (&bus_ce_n) && bus_we_n && bus_oe_n, "R12 idle at end",
        {31'h0, req_ready}, 32'h1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule